// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block moves one byte at a time over a three-wire synchronous serial link: a transfer clock, a data output and a data input. Host software programs a small register window with a mode word and a clock divider, then writes a byte into the transfer register. That write is the only start trigger. Eight bits go out while eight bits come in, and at the end the same register holds the received byte. The transmit and receive paths share that single register, so there is no separate holding buffer.

The transfer clock comes from one of two sources. In the first, the block divides its own clock and drives the clock pin itself, stopping after eight pulses. In the second, an external master supplies the clock pin, and the block follows its edges after a synchronizer. Mode bits choose the shift direction (least or most significant bit first) and the polarity. Polarity fixes which edge launches data, which edge samples it, and the resting level of the clock. In the first mode the data pin holds the final bit for half a transfer-clock period and then floats. In the second mode the data pin drives a programmable resting level between transfers. A one-cycle interrupt pulse marks every completed byte.

The host port is a plain register strobe with no back-pressure. A write is taken in the cycle it is presented and is never stalled. A data write that arrives while a byte is in flight is dropped, and an error flag records the drop.

Top module: `csio_unit`

## Requirements
- R1: Writing the data register (address 2) while `busy` is 0 starts a transfer. `busy` rises, exactly 8 bits are shifted out on `sdo`, and at the end reading address 2 returns the 8 bits sampled from `sdi`.
- R2: With the internal clock selected (mode bit 0 = 0), `sclk_out` has a period of 2(n+1) system clocks, where n is the divider (address 1). It makes exactly 8 pulses and then rests at its idle level: high when polarity (mode bit 1) is 0, low when it is 1. Reset selects the internal clock.
- R3: With mode bit 2 = 1, bit 0 is sent first and the first received bit lands in bit 0. With mode bit 2 = 0, bit 7 leads in both directions.
- R4: With polarity 0, `sdo` changes on the falling transfer-clock edge and `sdi` is sampled on the rising edge. With polarity 1 the two edges swap.
- R5: `irq` is a single-cycle pulse, issued exactly once per transfer, after the final sampling edge.
- R6: With the internal clock, `sdo_oe` stays high for n+1 system clocks after the final sampling edge and then falls. A data write inside that window drops `sdo_oe` in the following cycle and starts the next transfer.
- R7: With the external clock selected (mode bit 0 = 1), `sclk_oe` is 0 and `sdo_oe` is 1. `sdo` shows the resting value (mode bit 3) until the first launch edge of a transfer and again after it completes. The bits are clocked by `sclk_in` edges.
- R8: A data write while `busy` is 1 leaves the transfer and its data unchanged and sets `err`, which reads as status bit 1 at address 3. Writing address 3 with bit 1 set clears `err`.
- R9: After reset: `sclk_out` = 1, `sclk_oe` = 1, `sdo_oe` = 0, `busy` = 0, `irq` = 0, `err` = 0, and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken in the cycle it is high |
| reg_addr | input | 2 | Register select: 0 mode, 1 divider, 2 data, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sclk_in | input | 1 | Transfer clock from an external master |
| sclk_out | output | 1 | Transfer clock generated internally |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high-impedance |
| busy | output | 1 | A transfer is in flight |
| err | output | 1 | A data write was dropped while busy |
| irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit frame, an 8-bit divider and a two-stage clock synchronizer. At run time it sweeps the divider through 0, 2, 3 and 5. A divider of 0 brings in the fastest case, a one-cycle half period where the launch and sample edges sit on adjacent system clocks. Larger dividers leave room to land a write inside the data-hold window. In external mode the bench drives a transfer clock with a half period of six system clocks, which respects the synchronizer's speed limit, and covers both polarities and both resting levels.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic rest_lvl;   // bit 3: data pin level between transfers, external mode
    logic lsb_first;  // bit 2
    logic pol;        // bit 1
    logic ext_clk;    // bit 0
  } csio_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } csio_state_t;
endpackage

// File: rtl/csio_baud.sv
module csio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: ticks are n+1 cycles apart, so a nonzero divider never gives two in a row
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/csio_sync.sv
module csio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/csio_shift.sv
module csio_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         lead,
  input  logic         trail,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         dout,
  output logic         last
);
  localparam int BCW = $clog2(W + 1);

  logic [W-1:0] sr_q;
  logic [BCW-1:0] bits_q;
  logic dout_q;

  assign word = sr_q;
  assign dout = dout_q;
  assign last = trail && (bits_q == BCW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bits_q <= '0;
      dout_q <= 1'b0;
    end else if (load) begin
      sr_q   <= load_data;
      bits_q <= '0;
    end else begin
      if (lead) dout_q <= lsb_first ? sr_q[0] : sr_q[W-1];
      if (trail) begin
        sr_q   <= lsb_first ? {sdi, sr_q[W-1:1]} : {sr_q[W-2:0], sdi};
        bits_q <= bits_q + 1'b1;
      end
    end
  end

  // R1: a frame never counts past its width
  assert_bit_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BCW'(W));
endmodule

// File: rtl/csio_unit.sv
module csio_unit
  import csio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              err,
  output logic              irq
);
  csio_mode_t       mode_q;
  logic [DIV_W-1:0] div_q;
  csio_state_t      state_q;
  logic sclk_q, drv_q, err_q, irq_q;

  logic wr_mode, wr_div, wr_data, wr_stat, start, dropped;
  logic ext, pol, tick, tog, rise, fall;
  logic lead, trail, done, dout;
  logic [DATA_W-1:0] word;

  assign ext     = mode_q.ext_clk;
  assign pol     = mode_q.pol;
  assign wr_mode = reg_wr && reg_addr == ADDR_MODE;
  assign wr_div  = reg_wr && reg_addr == ADDR_DIV;
  assign wr_data = reg_wr && reg_addr == ADDR_DATA;
  assign wr_stat = reg_wr && reg_addr == ADDR_STAT;
  assign start   = wr_data && state_q != ST_RUN;
  assign dropped = wr_data && state_q == ST_RUN;

  csio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(!ext && state_q != ST_IDLE),
    .restart(start), .div(div_q), .tick(tick)
  );

  csio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk_in), .rise(rise), .fall(fall)
  );

  assign tog = tick && state_q == ST_RUN;

  always_comb begin
    if (ext) begin
      lead  = state_q == ST_RUN && (pol ? rise : fall);
      trail = state_q == ST_RUN && (pol ? fall : rise);
    end else begin
      lead  = tog && (sclk_q == ~pol);
      trail = tog && (sclk_q != ~pol);
    end
  end

  csio_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(reg_wdata),
    .lsb_first(mode_q.lsb_first), .lead(lead), .trail(trail), .sdi(sdi),
    .word(word), .dout(dout), .last(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= csio_mode_t'(reg_wdata[3:0]);
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      drv_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= done;
      if (dropped)                      err_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) err_q <= 1'b0;

      if (state_q != ST_RUN) sclk_q <= ~pol;
      else if (tog)          sclk_q <= ~sclk_q;

      if (start)                                    drv_q <= 1'b0;
      else if (lead)                                drv_q <= 1'b1;
      else if (ext && done)                         drv_q <= 1'b0;
      else if (!ext && state_q == ST_HOLD && tick)  drv_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_RUN;
        ST_RUN:  if (done)  state_q <= ext ? ST_IDLE : ST_HOLD;
        ST_HOLD: begin
          if (start)     state_q <= ST_RUN;
          else if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_MODE: reg_rdata = DATA_W'(mode_q);
      ADDR_DIV:  reg_rdata = DATA_W'(div_q);
      ADDR_DATA: reg_rdata = word;
      default:   reg_rdata = DATA_W'({err_q, state_q == ST_RUN});
    endcase
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = !ext;
  assign sdo      = (ext && !drv_q) ? mode_q.rest_lvl : dout;
  assign sdo_oe   = ext || drv_q;
  assign busy     = state_q == ST_RUN;
  assign err      = err_q;
  assign irq      = irq_q;

  // R5: the completion pulse lasts one cycle
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8: a dropped write raises the error flag
  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data) |=> err);

  // R8: a dropped write does not end the transfer in flight
  assert_drop_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data && !done) |=> busy);

  // R2: an idle internal clock rests at the level the polarity selects
  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && state_q == ST_IDLE && $past(state_q == ST_IDLE) && $stable(pol))
      |-> (sclk_out == ~pol));

  // R6: the data pin floats once the internal-clock hold window has closed
  assert_pin_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && $stable(ext) && state_q == ST_IDLE && $past(state_q == ST_IDLE))
      |-> !sdo_oe);
endmodule

// File: tb/csio_unit_tb.sv
module csio_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sclk_in = 1'b1;
  logic sclk_out, sclk_oe, sdo, sdo_oe, busy, err, irq;
  logic sdi_int = 1'b0;
  logic sdi_ext = 1'b0;
  logic ext_tb = 1'b0;
  logic sdi;

  int n_total = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  assign sdi = ext_tb ? sdi_ext : sdi_int;

  csio_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .busy(busy), .err(err), .irq(irq)
  );

  // slave model for the internal clock, settings written only by tasks
  logic m_pol = 1'b0;
  logic m_lsb = 1'b0;
  logic [7:0] m_slave = 8'd0;
  int arm_tok = 0;
  int seen_tok = 0;
  int lead_n = 0;
  int trail_n = 0;
  int period = 0;
  int last_trail = 0;
  int cyc = 0;
  int irq_cnt = 0;
  logic [7:0] cap_t = 8'd0;
  logic oe_at_trail = 1'b1;
  logic prev_sclk = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (arm_tok != seen_tok) begin
      seen_tok = arm_tok;
      lead_n = 0; trail_n = 0; period = 0; oe_at_trail = 1'b1;
    end else if (sclk_out !== prev_sclk && !ext_tb) begin
      if (sclk_out == m_pol) begin
        if (lead_n < 8) sdi_int = m_lsb ? m_slave[lead_n] : m_slave[7-lead_n];
        lead_n++;
      end else begin
        if (trail_n < 8) cap_t[trail_n] = sdo;
        if (!sdo_oe) oe_at_trail = 1'b0;
        if (trail_n > 0) period = cyc - last_trail;
        last_trail = cyc;
        trail_n++;
      end
    end
    prev_sclk = sclk_out;
  end

  function automatic logic [7:0] to_byte(logic [7:0] t, logic lsb);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[lsb ? k : 7-k] = t[k];
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic start_int(input logic pol, input logic lsb, input logic [7:0] n,
                           input logic [7:0] tx, input logic [7:0] slv);
    ext_tb = 1'b0; m_pol = pol; m_lsb = lsb; m_slave = slv;
    wr(csio_pkg::ADDR_MODE, {4'b0, 1'b0, lsb, pol, 1'b0});
    wr(csio_pkg::ADDR_DIV, n);
    repeat (2) @(negedge clk);
    arm_tok++;
    @(negedge clk);
    wr(csio_pkg::ADDR_DATA, tx);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(sclk_out == 1'b1, "R9", "sclk_out", sclk_out, 1);
    chk(sclk_oe == 1'b1, "R9", "sclk_oe", sclk_oe, 1);
    chk(sdo_oe == 1'b0, "R9", "sdo_oe", sdo_oe, 0);
    chk({busy, irq, err} == 3'b000, "R9", "busy/irq/err", {busy, irq, err}, 0);
    rd(csio_pkg::ADDR_DATA, d);
    chk(d == 8'h00, "R9", "data reg", d, 0);
  endtask

  // internal clock: frame content, period, pulse count, resting level, order, edges
  task automatic t_internal(input logic pol, input logic lsb, input logic [7:0] n,
                            input logic [7:0] tx, input logic [7:0] slv);
    logic [7:0] d;
    bit ok;
    int irq0;
    irq0 = irq_cnt;
    start_int(pol, lsb, n, tx, slv);
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    wait_irq(ok);
    chk(ok, "R5", "irq seen", ok, 1);
    repeat (4 * (n + 2)) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after end", busy, 0);
    chk(trail_n == 8, "R2", "sample edge count", trail_n, 8);
    chk(lead_n == 8, "R2", "launch edge count", lead_n, 8);
    chk(period == 2 * (n + 1), "R2", "clock period", period, 2 * (n + 1));
    chk(sclk_out == ~pol, "R2", "resting clock", sclk_out, ~pol);
    chk(to_byte(cap_t, lsb) == tx, lsb ? "R3" : "R4", "bits sent", to_byte(cap_t, lsb), tx);
    chk(oe_at_trail, "R4", "sdo driven at sample edges", oe_at_trail, 1);
    rd(csio_pkg::ADDR_DATA, d);
    chk(d == slv, lsb ? "R3" : "R1", "byte received", d, slv);
    chk(irq_cnt - irq0 == 1, "R5", "irq pulses", irq_cnt - irq0, 1);
    chk(sdo_oe == 1'b0, "R6", "sdo floats after hold", sdo_oe, 0);
  endtask

  task automatic t_hold;
    bit ok;
    int cnt;
    start_int(1'b0, 1'b0, 8'd3, 8'hC3, 8'h18);
    wait_irq(ok);
    cnt = 0;
    while (sdo_oe && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == 4, "R6", "hold length", cnt, 4);
    arm_tok++;
    @(negedge clk);
    wr(csio_pkg::ADDR_DATA, 8'h96);
    wait_irq(ok);
    arm_tok++;
    @(negedge clk);
    chk(sdo_oe == 1'b1, "R6", "sdo still held", sdo_oe, 1);
    wr(csio_pkg::ADDR_DATA, 8'h2D);
    chk(sdo_oe == 1'b0, "R6", "sdo floats on write in hold", sdo_oe, 0);
    chk(busy == 1'b1, "R6", "new transfer started", busy, 1);
    wait_irq(ok);
    repeat (12) @(negedge clk);
    chk(to_byte(cap_t, 1'b0) == 8'h2D, "R6", "next frame bits", to_byte(cap_t, 1'b0), 8'h2D);
  endtask

  task automatic t_busy_write;
    logic [7:0] d;
    bit ok;
    start_int(1'b0, 1'b0, 8'd5, 8'h5A, 8'hE7);
    repeat (10) @(negedge clk);
    wr(csio_pkg::ADDR_DATA, 8'hFF);
    chk(busy == 1'b1, "R8", "busy after dropped write", busy, 1);
    chk(err == 1'b1, "R8", "err set", err, 1);
    wait_irq(ok);
    repeat (20) @(negedge clk);
    chk(to_byte(cap_t, 1'b0) == 8'h5A, "R8", "frame unchanged", to_byte(cap_t, 1'b0), 8'h5A);
    rd(csio_pkg::ADDR_DATA, d);
    chk(d == 8'hE7, "R8", "received byte", d, 8'hE7);
    rd(csio_pkg::ADDR_STAT, d);
    chk(d == 8'h02, "R8", "status reads err", d, 8'h02);
    wr(csio_pkg::ADDR_STAT, 8'h02);
    chk(err == 1'b0, "R8", "err cleared", err, 0);
  endtask

  task automatic t_external(input logic pol, input logic lsb, input logic rest,
                            input logic [7:0] tx, input logic [7:0] slv);
    logic [7:0] d;
    logic [7:0] capx;
    int irq0;
    ext_tb = 1'b1;
    sclk_in = ~pol;
    wr(csio_pkg::ADDR_MODE, {4'b0, rest, lsb, pol, 1'b1});
    repeat (6) @(negedge clk);
    chk(sclk_oe == 1'b0, "R7", "sclk_oe", sclk_oe, 0);
    chk(sdo_oe == 1'b1, "R7", "sdo_oe", sdo_oe, 1);
    chk(sdo == rest, "R7", "rest level idle", sdo, rest);
    irq0 = irq_cnt;
    wr(csio_pkg::ADDR_DATA, tx);
    repeat (4) @(negedge clk);
    chk(sdo == rest, "R7", "rest level before launch", sdo, rest);
    for (int k = 0; k < 8; k++) begin
      sclk_in = pol;
      sdi_ext = lsb ? slv[k] : slv[7-k];
      repeat (6) @(negedge clk);
      capx[k] = sdo;
      sclk_in = ~pol;
      repeat (6) @(negedge clk);
    end
    chk(irq_cnt - irq0 == 1, "R7", "irq pulses", irq_cnt - irq0, 1);
    chk(busy == 1'b0, "R7", "busy after frame", busy, 0);
    chk(to_byte(capx, lsb) == tx, "R7", "bits sent", to_byte(capx, lsb), tx);
    rd(csio_pkg::ADDR_DATA, d);
    chk(d == slv, "R7", "byte received", d, slv);
    chk(sdo == rest, "R7", "rest level after frame", sdo, rest);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal(1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C);
    t_internal(1'b1, 1'b1, 8'd0, 8'h6B, 8'hD2);
    t_internal(1'b0, 1'b1, 8'd3, 8'h01, 8'h80);
    t_hold();
    t_busy_write();
    t_external(1'b0, 1'b0, 1'b1, 8'h9E, 8'h47);
    t_external(1'b1, 1'b1, 1'b0, 8'h35, 8'hB8);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule